// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes integer quotients and remainders one bit per clock with a restoring shift-and-subtract loop. It serves an execution pipeline that needs signed and unsigned division and remainder on full-width (64-bit) operands and on 32-bit word operands. It also supports an extended divide, in which the dividend is the first operand placed above an all-zero lower half, so the quotient is a fixed-point ratio. Each operation is launched with a one-cycle `start` while the unit is idle. The unit stays `busy` for a fixed number of cycles. It then raises `done` for one cycle, and at that edge the result, the overflow flag and a four-bit condition field become valid.

Signed operations divide magnitudes and correct the signs afterwards. All undefined cases give a result of zero, and the flag reports them when overflow enabling is set. These cases are a zero divisor, the most negative value divided by minus one, and an extended quotient that does not fit. The condition field classifies the result as negative, positive or zero when recording is requested.

Top module: `idiv_unit`

## Requirements
- R1: Operation codes on `op`: 0 signed divide, 1 unsigned divide, 2 signed remainder, 3 unsigned remainder, 4 signed extended divide, 5 unsigned extended divide; codes 6 and 7 act as unsigned divide. Unsigned forms return floor(a/b) or a mod b.
- R2: Signed divide truncates toward zero. The quotient is negative when the operand signs differ. A signed remainder takes the sign of the dividend.
- R3: A zero divisor (in the operand width used) makes the operation invalid: `result` is zero and `ov` equals `oe`.
- R4: A non-extended signed divide or remainder of the most negative value by minus one is invalid and handled as in R3.
- R5: With `word` = 1 only bits 31:0 of each operand are used, the result sits in bits 31:0, and bits 63:32 of `result` are zero.
- R6: Unsigned extended divide computes (a·2^W)/b, with W = 64, or 32 with `word`. It is invalid whenever a ≥ b, because the quotient would not fit in W bits.
- R7: Signed extended divide computes (a·2^W)/b with sign correction. It is invalid when the quotient lies outside the signed W-bit range [-2^(W-1), 2^(W-1)-1].
- R8: `ov` is never set when `oe` was 0 at the accepting edge, even for invalid operations.
- R9: With `rc` = 1, `cr` = {lt, gt, eq, ov}: bit 3 is the sign bit of the W-bit result, bit 1 is set when the result is zero, bit 2 is set when neither holds, and bit 0 copies `ov`. With `rc` = 0, `cr` is zero.
- R10: After reset the unit is idle and all outputs are zero. `done` rises on the 65th rising edge after the accepting edge (the 33rd with `word`) and lasts exactly one cycle.
- R11: `start` is ignored while `busy`. `result`, `ov` and `cr` change only in a cycle where `done` is raised.
- R12: A `start` driven in the cycle where `done` is high is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken when not busy |
| op | input | 3 | Operation code (R1) |
| word | input | 1 | Selects 32-bit word form |
| oe | input | 1 | Overflow reporting enable |
| rc | input | 1 | Condition field recording enable |
| opa | input | 64 | Dividend operand |
| opb | input | 64 | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder |
| ov | output | 1 | Invalid or non-fitting operation, when enabled |
| cr | output | 4 | Condition field {lt, gt, eq, ov} |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle. This happens because `busy` drops together with `done`. The scoreboard driver launches each new operation at the first falling edge where `busy` is low, which is the cycle in which `done` is high, so every operation after the first is back-to-back. The monitor judges each item by its fields and by the number of cycles between the launch stamp and the observed pulse. A start that is lost or taken twice shows up as a latency error or as an unexpected pulse.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  typedef enum logic [2:0] {
    OPC_DIV_S  = 3'd0,
    OPC_DIV_U  = 3'd1,
    OPC_REM_S  = 3'd2,
    OPC_REM_U  = 3'd3,
    OPC_XDIV_S = 3'd4,
    OPC_XDIV_U = 3'd5
  } idiv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } idiv_state_e;

  function automatic logic op_signed(input logic [2:0] op);
    return (op == OPC_DIV_S) || (op == OPC_REM_S) || (op == OPC_XDIV_S);
  endfunction

  function automatic logic op_remainder(input logic [2:0] op);
    return (op == OPC_REM_S) || (op == OPC_REM_U);
  endfunction

  function automatic logic op_extended(input logic [2:0] op);
    return (op == OPC_XDIV_S) || (op == OPC_XDIV_U);
  endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            word_i,
  input  logic            sgn_i,
  input  logic            ext_i,
  output logic [XLEN-1:0] mag_b_o,
  output logic [XLEN-1:0] rem_o,
  output logic [XLEN-1:0] dvd_o,
  output logic            neg_a_o,
  output logic            neg_b_o,
  output logic            zero_div_o,
  output logic            min_neg_o,
  output logic            ext_big_o
);
  localparam int HLEN = XLEN / 2;
  localparam logic [XLEN-1:0] MOST_NEG_D = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] MOST_NEG_W = {{HLEN{1'b0}}, 1'b1, {(HLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] ONE        = {{(XLEN-1){1'b0}}, 1'b1};

  // Bring an operand to full width according to form and signedness.
  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                           input logic w, input logic s);
    if (w) return s ? {{HLEN{v[HLEN-1]}}, v[HLEN-1:0]} : {{HLEN{1'b0}}, v[HLEN-1:0]};
    return v;
  endfunction

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v, input logic neg);
    return neg ? (~v + ONE) : v;
  endfunction

  logic [XLEN-1:0] wide_a, wide_b, mag_a;

  always_comb begin
    wide_a     = widen(a_i, word_i, sgn_i);
    wide_b     = widen(b_i, word_i, sgn_i);
    neg_a_o    = sgn_i & wide_a[XLEN-1];
    neg_b_o    = sgn_i & wide_b[XLEN-1];
    mag_a      = magnitude(wide_a, neg_a_o);
    mag_b_o    = magnitude(wide_b, neg_b_o);
    zero_div_o = (mag_b_o == '0);
    min_neg_o  = sgn_i & ~ext_i & neg_a_o & neg_b_o & (mag_b_o == ONE) &
                 (mag_a == (word_i ? MOST_NEG_W : MOST_NEG_D));
    ext_big_o  = ext_i & (mag_a >= mag_b_o);
    rem_o      = ext_i ? mag_a : '0;
    dvd_o      = ext_i ? '0 : (word_i ? (mag_a << HLEN) : mag_a);
  end

endmodule

// File: rtl/idiv_step.sv
module idiv_step #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rem_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dsr_i,
  output logic [XLEN-1:0] rem_o,
  output logic [XLEN-1:0] dvd_o,
  output logic            qbit_o
);
  // One restoring step: shift one dividend bit into the partial remainder,
  // subtract when it fits, and shift the quotient bit into the dividend slot.
  function automatic logic [XLEN:0] trial_sub(input logic [XLEN:0] shifted,
                                              input logic [XLEN-1:0] dsr);
    return shifted - {1'b0, dsr};
  endfunction

  logic [XLEN:0] shifted, diff;

  always_comb begin
    shifted = {rem_i, dvd_i[XLEN-1]};
    diff    = trial_sub(shifted, dsr_i);
    qbit_o  = (shifted >= {1'b0, dsr_i});
    rem_o   = qbit_o ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    dvd_o   = {dvd_i[XLEN-2:0], qbit_o};
  end

endmodule

// File: rtl/idiv_fix.sv
module idiv_fix #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] quot_i,
  input  logic [XLEN-1:0] rem_i,
  input  logic            neg_a_i,
  input  logic            neg_b_i,
  input  logic            sgn_i,
  input  logic            mod_i,
  input  logic            ext_i,
  input  logic            word_i,
  input  logic            bad_i,
  input  logic            oe_i,
  input  logic            rc_i,
  output logic [XLEN-1:0] res_o,
  output logic            ov_o,
  output logic [3:0]      cr_o,
  output logic            unfit_o
);
  localparam int HLEN = XLEN / 2;
  localparam logic [XLEN-1:0] LIM_D = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] LIM_W = {{HLEN{1'b0}}, 1'b1, {(HLEN-1){1'b0}}};

  function automatic logic [XLEN-1:0] negate_if(input logic [XLEN-1:0] v, input logic n);
    return n ? (~v + {{(XLEN-1){1'b0}}, 1'b1}) : v;
  endfunction

  // Signed range check of a quotient magnitude against the form's limit.
  function automatic logic signed_fits(input logic [XLEN-1:0] mag, input logic neg,
                                       input logic [XLEN-1:0] lim);
    return neg ? (mag <= lim) : (mag < lim);
  endfunction

  logic [XLEN-1:0] q_mag, q_val, r_val, raw, trimmed;
  logic            neg_q, bad_all, lt, eq;

  always_comb begin
    q_mag   = word_i ? {{HLEN{1'b0}}, quot_i[HLEN-1:0]} : quot_i;
    neg_q   = sgn_i & (neg_a_i ^ neg_b_i);
    q_val   = negate_if(q_mag, neg_q);
    r_val   = negate_if(rem_i, sgn_i & neg_a_i);
    unfit_o = ext_i & sgn_i & ~signed_fits(q_mag, neg_q, word_i ? LIM_W : LIM_D);
    bad_all = bad_i | unfit_o;
    raw     = mod_i ? r_val : q_val;
    trimmed = word_i ? {{HLEN{1'b0}}, raw[HLEN-1:0]} : raw;
    res_o   = bad_all ? '0 : trimmed;
    ov_o    = oe_i & bad_all;
    lt      = word_i ? res_o[HLEN-1] : res_o[XLEN-1];
    eq      = (res_o == '0);
    cr_o    = rc_i ? {lt, ~lt & ~eq, eq, ov_o} : 4'b0000;
  end

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic            word,
  input  logic            oe,
  input  logic            rc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            ov,
  output logic [3:0]      cr
);
  import idiv_pkg::*;

  localparam int HLEN = XLEN / 2;
  localparam int CW   = $clog2(XLEN);
  localparam logic [CW-1:0] LAST_D = CW'(XLEN - 1);
  localparam logic [CW-1:0] LAST_W = CW'(HLEN - 1);

  idiv_state_e     state_q;
  logic [CW-1:0]   cnt_q;
  logic            sgn_q, mod_q, ext_q, word_q, oe_q, rc_q;
  logic            neg_a_q, neg_b_q, bad_q;
  logic [XLEN-1:0] dsr_q, rem_q, dvd_q;

  // Named internal events, observed by the bound checker.
  logic accept, step_en, last_step;

  logic            in_sgn, in_mod, in_ext;
  logic [XLEN-1:0] p_mag_b, p_rem, p_dvd;
  logic            p_neg_a, p_neg_b, p_zero, p_minneg, p_big;
  logic [XLEN-1:0] s_rem, s_dvd;
  logic            s_qbit;
  logic [XLEN-1:0] f_res;
  logic            f_ov, f_unfit;
  logic [3:0]      f_cr;

  always_comb begin
    in_sgn = op_signed(op);
    in_mod = op_remainder(op);
    in_ext = op_extended(op);
  end

  idiv_prep #(.XLEN(XLEN)) u_prep (
    .a_i(opa), .b_i(opb), .word_i(word), .sgn_i(in_sgn), .ext_i(in_ext),
    .mag_b_o(p_mag_b), .rem_o(p_rem), .dvd_o(p_dvd),
    .neg_a_o(p_neg_a), .neg_b_o(p_neg_b), .zero_div_o(p_zero),
    .min_neg_o(p_minneg), .ext_big_o(p_big)
  );

  idiv_step #(.XLEN(XLEN)) u_step (
    .rem_i(rem_q), .dvd_i(dvd_q), .dsr_i(dsr_q),
    .rem_o(s_rem), .dvd_o(s_dvd), .qbit_o(s_qbit)
  );

  idiv_fix #(.XLEN(XLEN)) u_fix (
    .quot_i(dvd_q), .rem_i(rem_q), .neg_a_i(neg_a_q), .neg_b_i(neg_b_q),
    .sgn_i(sgn_q), .mod_i(mod_q), .ext_i(ext_q), .word_i(word_q),
    .bad_i(bad_q), .oe_i(oe_q), .rc_i(rc_q),
    .res_o(f_res), .ov_o(f_ov), .cr_o(f_cr), .unfit_o(f_unfit)
  );

  assign busy      = (state_q != ST_IDLE);
  assign accept    = start & ~busy;
  assign step_en   = (state_q == ST_RUN);
  assign last_step = step_en & (cnt_q == (word_q ? LAST_W : LAST_D));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      mod_q   <= 1'b0;
      ext_q   <= 1'b0;
      word_q  <= 1'b0;
      oe_q    <= 1'b0;
      rc_q    <= 1'b0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      bad_q   <= 1'b0;
      dsr_q   <= '0;
      rem_q   <= '0;
      dvd_q   <= '0;
      done    <= 1'b0;
      result  <= '0;
      ov      <= 1'b0;
      cr      <= 4'b0000;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            sgn_q   <= in_sgn;
            mod_q   <= in_mod;
            ext_q   <= in_ext;
            word_q  <= word;
            oe_q    <= oe;
            rc_q    <= rc;
            neg_a_q <= p_neg_a;
            neg_b_q <= p_neg_b;
            bad_q   <= p_zero | p_minneg | p_big;
            dsr_q   <= p_mag_b;
            rem_q   <= p_rem;
            dvd_q   <= p_dvd;
          end
        end
        ST_RUN: begin
          rem_q <= s_rem;
          dvd_q <= s_dvd;
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= ST_FIX;
        end
        ST_FIX: begin
          result  <= f_res;
          ov      <= f_ov;
          cr      <= f_cr;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idiv_checker.sv
module idiv_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            word,
  input logic            oe,
  input logic            rc,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result,
  input logic            ov,
  input logic [3:0]      cr,
  input logic            accept,
  input logic            step_en,
  input logic            last_step
);
  localparam int HLEN = XLEN / 2;
  localparam int LW   = $clog2(XLEN) + 2;

  logic [LW-1:0] lat_q;
  logic          word_l, oe_l, rc_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      word_l <= 1'b0;
      oe_l   <= 1'b0;
      rc_l   <= 1'b0;
    end else if (accept) begin
      lat_q  <= '0;
      word_l <= word;
      oe_l   <= oe;
      rc_l   <= rc;
    end else if (busy) begin
      lat_q  <= lat_q + 1'b1;
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (word_l ? LW'(HLEN + 1) : LW'(XLEN + 1))));

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_step, 2));

  p_accept_runs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && step_en && !done));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(ov) && $stable(cr)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !oe_l) |-> !ov);

  p_zero_on_ov_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ov) |-> (result == '0));

  p_cr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rc_l) |-> (cr == 4'b0000));

  p_cr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rc_l) |-> $onehot(cr[3:1]));

  p_word_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && word_l) |-> (result[XLEN-1:HLEN] == '0));

endmodule

bind idiv_unit idiv_checker #(.XLEN(XLEN)) u_idiv_chk (
  .clk(clk), .rst_n(rst_n), .word(word), .oe(oe), .rc(rc),
  .busy(busy), .done(done), .result(result), .ov(ov), .cr(cr),
  .accept(accept), .step_en(step_en), .last_step(last_step)
);

// File: tb/idiv_unit_test.sv
module idiv_unit_test;

  typedef struct {
    logic [63:0] res;
    logic        ov;
    logic [3:0]  cr;
    int          issue;
    int          lat;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        word = 1'b0, oe = 1'b0, rc = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        busy, done, ov;
  logic [63:0] result;
  logic [3:0]  cr;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  exp_t sb_q[$];

  idiv_unit #(.XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
    .oe(oe), .rc(rc), .opa(opa), .opb(opb), .busy(busy), .done(done),
    .result(result), .ov(ov), .cr(cr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model built from the requirements with wide signed arithmetic.
  function automatic exp_t model(input logic [2:0] o, input logic w, input logic e_oe,
                                 input logic e_rc, input logic [63:0] a, input logic [63:0] b,
                                 input string tag);
    exp_t x;
    int n = w ? 32 : 64;
    logic s = (o == 3'd0) || (o == 3'd2) || (o == 3'd4);
    logic m = (o == 3'd2) || (o == 3'd3);
    logic e = (o == 3'd4) || (o == 3'd5);
    logic signed [129:0] sa, sb, dd, q, r, lo, hi, v;
    logic bad, lt, eq;
    if (w) begin
      sa = {{98{s & a[31]}}, a[31:0]};
      sb = {{98{s & b[31]}}, b[31:0]};
    end else begin
      sa = {{66{s & a[63]}}, a};
      sb = {{66{s & b[63]}}, b};
    end
    dd  = e ? (sa <<< n) : sa;
    bad = (sb == 0);
    if (s && !e && (w ? (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF)
                      : (a == 64'h8000_0000_0000_0000 && b == '1))) bad = 1'b1;
    q = 0;
    r = 0;
    if (!bad) begin
      q = dd / sb;
      r = dd % sb;
      lo = s ? -(130'sd1 <<< (n - 1)) : 130'sd0;
      hi = s ? ((130'sd1 <<< (n - 1)) - 1) : ((130'sd1 <<< n) - 1);
      if (!m && (q < lo || q > hi)) bad = 1'b1;
    end
    v     = bad ? 130'sd0 : (m ? r : q);
    x.res = w ? {32'h0, v[31:0]} : v[63:0];
    x.ov  = e_oe & bad;
    lt    = w ? x.res[31] : x.res[63];
    eq    = (x.res == 0);
    x.cr  = e_rc ? {lt, ~lt & ~eq, eq, x.ov} : 4'b0000;
    x.lat = n + 2;
    x.tag = tag;
    x.issue = 0;
    return x;
  endfunction

  // Driver: waits until the unit can accept, pushes the expectation, pulses start.
  task automatic issue(input logic [2:0] o, input logic w, input logic e_oe, input logic e_rc,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t x;
    @(negedge clk);
    while (busy) @(negedge clk);
    x = model(o, w, e_oe, e_rc, a, b, tag);
    x.issue = cyc;
    sb_q.push_back(x);
    op = o; word = w; oe = e_oe; rc = e_rc; opa = a; opb = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R11: requests while busy must be dropped.
  task automatic junk_while_busy();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (busy) begin
        op = 3'd1; word = 1'b0; oe = 1'b1; rc = 1'b1;
        opa = 64'd999 + 64'(k); opb = 64'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
  endtask

  // Monitor: pops and compares on each completion pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t x;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected done: actual result=%h expected no completion", result);
      end else begin
        x = sb_q.pop_front();
        if (result !== x.res || ov !== x.ov || cr !== x.cr) begin
          fails++;
          $display("FAIL %s: actual res=%h ov=%b cr=%b expected res=%h ov=%b cr=%b",
                   x.tag, result, ov, cr, x.res, x.ov, x.cr);
        end
        checks++;
        if (cyc - x.issue != x.lat) begin
          fails++;
          $display("FAIL R10/R12 latency (%s): actual %0d expected %0d",
                   x.tag, cyc - x.issue, x.lat);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || result !== '0 || ov !== 1'b0 || cr !== 4'b0) begin
      fails++;
      $display("FAIL R10 reset: actual busy=%b done=%b res=%h ov=%b cr=%b expected all zero",
               busy, done, result, ov, cr);
    end

    // R1 unsigned forms
    issue(3'd1, 0, 1, 0, 64'd100, 64'd7, "R1 divu");
    issue(3'd3, 0, 1, 0, 64'd100, 64'd7, "R1 modu");
    issue(3'd1, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R1 divu large");
    issue(3'd3, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, "R1 modu large");
    issue(3'd6, 0, 1, 1, 64'd81, 64'd9, "R1 code6");
    issue(3'd7, 0, 1, 0, 64'd82, 64'd9, "R1 code7");
    // R2 signed forms
    issue(3'd0, 0, 1, 1, -64'sd100, 64'd7, "R2 divs neg/pos");
    issue(3'd2, 0, 1, 1, -64'sd100, 64'd7, "R2 mods neg/pos");
    issue(3'd0, 0, 1, 1, 64'd100, -64'sd7, "R2 divs pos/neg");
    issue(3'd2, 0, 1, 1, 64'd100, -64'sd7, "R2 mods pos/neg");
    issue(3'd0, 0, 0, 1, -64'sd7, -64'sd2, "R2 divs neg/neg");
    // R3 zero divisor
    issue(3'd0, 0, 1, 1, 64'd55, 64'd0, "R3 divs by zero");
    issue(3'd3, 0, 1, 1, 64'd55, 64'd0, "R3 modu by zero");
    issue(3'd1, 1, 1, 1, 64'd55, 64'hFFFF_FFFF_0000_0000, "R3 word zero low half");
    // R4 most negative by minus one
    issue(3'd0, 0, 1, 1, 64'h8000_0000_0000_0000, '1, "R4 divs minneg");
    issue(3'd2, 0, 1, 1, 64'h8000_0000_0000_0000, '1, "R4 mods minneg");
    issue(3'd0, 1, 1, 1, 64'h1234_5678_8000_0000, 64'h0000_0000_FFFF_FFFF, "R4 word minneg");
    issue(3'd0, 0, 1, 1, 64'h8000_0000_0000_0000, 64'd1, "R4 minneg by one valid");
    // R5 word forms with junk upper halves
    issue(3'd0, 1, 1, 1, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, "R5 word divs");
    issue(3'd2, 1, 1, 1, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, "R5 word mods");
    issue(3'd1, 1, 1, 1, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0010, "R5 word divu");
    issue(3'd3, 1, 0, 1, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0010, "R5 word modu");
    // R6 unsigned extended
    issue(3'd5, 0, 1, 1, 64'd1, 64'd3, "R6 xdivu fits");
    issue(3'd5, 0, 1, 1, 64'd5, 64'd3, "R6 xdivu a>=b");
    issue(3'd5, 0, 1, 1, 64'd3, 64'd3, "R6 xdivu a==b");
    issue(3'd5, 1, 1, 1, 64'd1, 64'd2, "R6 word xdivu");
    // R7 signed extended
    issue(3'd4, 0, 1, 1, 64'd1, -64'sd4, "R7 xdivs fits");
    issue(3'd4, 0, 1, 1, 64'd1, 64'd2, "R7 xdivs +2^63 overflow");
    issue(3'd4, 0, 1, 1, -64'sd1, 64'd2, "R7 xdivs -2^63 fits");
    issue(3'd4, 1, 1, 1, 64'd1, 64'd2, "R7 word xdivs overflow");
    issue(3'd4, 1, 1, 1, 64'hFFFF_FFFF, 64'd2, "R7 word xdivs -2^31 fits");
    // R8 overflow suppressed without oe
    issue(3'd0, 0, 0, 1, 64'd9, 64'd0, "R8 zero divisor oe off");
    issue(3'd5, 0, 0, 0, 64'd9, 64'd2, "R8 xdivu unfit oe off");
    // R9 condition field
    issue(3'd0, 0, 1, 1, 64'd3, 64'd7, "R9 zero result");
    issue(3'd0, 0, 1, 0, -64'sd70, 64'd7, "R9 rc off");
    // R11 requests while busy are dropped
    issue(3'd1, 0, 1, 1, 64'd1000, 64'd10, "R11 base");
    junk_while_busy();
    // R12 back-to-back pair in word form
    issue(3'd1, 1, 1, 1, 64'd77, 64'd7, "R12 first");
    issue(3'd3, 1, 1, 1, 64'd78, 64'd7, "R12 second");

    while (sb_q.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || sb_q.size() != 0) begin
      fails++;
      $display("FAIL R11 idle: actual busy=%b pending=%0d expected 0/0", busy, sb_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule